// File: doc/BRIEF.md
# Multiple single-input-change BIST pattern generator

This block produces low-switching self-test stimulus for a circuit under test. A twisted-ring (Johnson) counter of L stages supplies a sequence in which each state differs from the one before it in exactly one stage. A maximal-length pseudo-random seed register is XORed onto those stages. While the seed holds, every pattern applied to the circuit is a single-input-change step away from the previous one. No pattern repeats until the ring has visited all of its 2L states. The seed then steps and a new family of patterns begins.

One set of hardware serves two application schemes, picked by `mode_i`:

- **Test-per-clock** (`mode_i` = 0): a full L-bit parallel vector is offered on `vec_o` at every accepted transfer.
- **Test-per-scan** (`mode_i` = 1): the block drives M serial scan-in bits, one per chain. It runs L shift cycles with scan-enable high, then one capture cycle with scan-enable low. The ring advances once per completed load.

Output transfers follow a valid/ready rule:

- `out_valid_o` equals `en_i`.
- A transfer (shift, capture or parallel vector) happens only in a cycle where `out_valid_o` and `out_ready_i` are both high.
- While the consumer holds `out_ready_i` low, every data output and all internal state stay frozen.
- The initialisation strobe acts whether or not a transfer happens.

Top module: `msic_tpg`

## Requirements
- R1: After synchronous reset, the ring is all zeros, the seed equals the parameter `SEED_RESET` (default 8'h5A), `vec_o` equals the seed (bit j = seed[j mod SW]), `done_o` is 0, the shift position is 0, and `out_valid_o` follows `en_i`.
- R2: In test-per-clock mode (`mode_i`=0), `vec_o[j]` = seed[j mod SW] XOR ring[j]. The ring advances once per accepted transfer. `scan_en_o` and `scan_in_o` are held at 0.
- R3: The ring is a twisted shifter (shift toward the MSB, inverted MSB fed into bit 0). Starting from zero, after p advances bit k is 1 exactly when k < p <= k+L, so it cycles through 2L distinct states.
- R4: While the seed is unchanged, each new vector differs from the previous one in exactly one bit, and no vector repeats within one seed period.
- R5: The seed register is a shift-left Fibonacci LFSR whose feedback enters bit 0. For SW=8 the feedback is the XOR of bits 7, 5, 4 and 3. It steps only when the ring wraps from its last state back to zero, or on `init_i`, and it is never zero.
- R6: `done_o` is high for exactly one cycle: the cycle after the transfer that completes 2L ring states under the current seed.
- R7: In test-per-scan mode (`mode_i`=1), shift positions k = 0..L-1 each take one accepted transfer with `scan_en_o`=1 and `scan_in_o[i]` = seed[i] XOR ring[k]. They are followed by one capture transfer with `scan_en_o`=0 and `scan_in_o`=0, which advances the ring. In test-per-clock mode the shift position is held at 0.
- R8: When `out_valid_o`=1 and `out_ready_i`=0 with no `init_i`, the outputs and state do not change in the next cycle.
- R9: `init_i` clears the ring and shift position and steps the seed exactly once without raising `done_o`. It takes precedence over a ring wrap in the same cycle, so the seed still steps only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_i | input | 1 | Initialisation strobe: restart ring, step seed |
| mode_i | input | 1 | 0 test-per-clock, 1 test-per-scan |
| en_i | input | 1 | Run enable; drives out_valid_o |
| out_ready_i | input | 1 | Consumer accepts the current output |
| out_valid_o | output | 1 | Current output is valid |
| vec_o | output | L | Parallel test vector |
| scan_in_o | output | M | Serial bit for each scan chain |
| scan_en_o | output | 1 | High in shift cycles, low in capture |
| done_o | output | 1 | One-cycle pulse after a full ring period |

## Verification
The two functions that can collide are:

- the ring wrap, which steps the seed and raises `done_o`;
- the initialisation strobe, which also steps the seed.

The bench runs the test-per-clock scheme with the consumer ready. It watches its own model of the ring position, and asserts `init_i` in exactly the cycle where the last ring state is accepted. It then judges that the seed moved by one LFSR step and not two, that `done_o` stayed low, and that the ring restarted from zero.

A second collision comes from back-pressure. `out_ready_i` is dropped on the cycle a wrap would occur, and the bench confirms that neither the seed nor `done_o` moves until the transfer is accepted.

// File: rtl/msic_pkg.sv
package msic_pkg;

  typedef enum logic {
    MODE_PER_CLOCK = 1'b0,
    MODE_PER_SCAN  = 1'b1
  } tpg_mode_e;

  // Feedback masks for maximal-length shift-left Fibonacci LFSRs.
  // Bit (t-1) set means register bit t-1 takes part in the feedback XOR.
  function automatic logic [15:0] lfsr_taps(input int w);
    logic [15:0] m;
    case (w)
      3:       m = 16'h0006;
      4:       m = 16'h000C;
      5:       m = 16'h0014;
      6:       m = 16'h0030;
      7:       m = 16'h0060;
      8:       m = 16'h00B8;
      9:       m = 16'h0110;
      10:      m = 16'h0240;
      11:      m = 16'h0500;
      12:      m = 16'h0829;
      13:      m = 16'h100D;
      14:      m = 16'h2015;
      15:      m = 16'h6000;
      16:      m = 16'hD008;
      default: m = 16'h0000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/msic_johnson.sv
module msic_johnson #(
  parameter int L = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         adv_i,
  output logic [L-1:0] state_o,
  output logic         wrap_o
);
  localparam logic [L-1:0] LAST_STATE = {1'b1, {(L-1){1'b0}}};

  logic [L-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      state_q <= '0;
    end else if (adv_i) begin
      state_q <= {state_q[L-2:0], ~state_q[L-1]};
    end
  end

  assign state_o = state_q;
  assign wrap_o  = adv_i && !clr_i && (state_q == LAST_STATE);

  // Each advance flips exactly one stage.
  assert_ring_single_flip_R3: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !clr_i) |=> ($countones(state_q ^ $past(state_q)) == 1));

  // After a wrap the ring is back at zero.
  assert_ring_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (state_q == '0));

  // Without an advance or a clear the ring holds.
  assert_ring_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !clr_i) |=> $stable(state_q));

endmodule

// File: rtl/msic_lfsr.sv
module msic_lfsr
  import msic_pkg::*;
#(
  parameter int          SW         = 8,
  parameter int unsigned SEED_RESET = 32'h5A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  output logic [SW-1:0] seed_o
);
  localparam logic [15:0]   TAP_ALL = lfsr_taps(SW);
  localparam logic [SW-1:0] TAPS    = TAP_ALL[SW-1:0];
  localparam logic [SW-1:0] SEED_V  = SW'(SEED_RESET);

  generate
    if (SW < 3 || SW > 16) begin : g_bad_width
      $error("seed width out of supported range");
    end
    if (SEED_V == '0) begin : g_bad_seed
      $error("reset seed must be nonzero");
    end
  endgenerate

  logic [SW-1:0] q;
  logic          fb;

  assign fb = ^(q & TAPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= SEED_V;
    end else if (step_i) begin
      q <= {q[SW-2:0], fb};
    end
  end

  assign seed_o = q;

  assert_seed_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    (q != '0));

  assert_seed_holds_R5: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(q));

endmodule

// File: rtl/msic_scan_seq.sv
module msic_scan_seq #(
  parameter int L  = 8,
  parameter int CW = $clog2(L + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic          step_i,
  output logic [CW-1:0] pos_o,
  output logic          shift_o,
  output logic          capture_o
);
  localparam logic [CW-1:0] CAP_POS = CW'(L);

  logic [CW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i || !run_i) begin
      pos_q <= '0;
    end else if (step_i) begin
      pos_q <= (pos_q == CAP_POS) ? '0 : pos_q + 1'b1;
    end
  end

  assign pos_o     = pos_q;
  assign capture_o = (pos_q == CAP_POS);
  assign shift_o   = !capture_o;

  assert_pos_in_range_R7: assert property (@(posedge clk) disable iff (rst)
    (pos_q <= CAP_POS));

  // The last accepted shift is always followed by the capture slot.
  assert_capture_follows_R7: assert property (@(posedge clk) disable iff (rst)
    (run_i && step_i && !clr_i && pos_q == CAP_POS - 1'b1) |=> capture_o);

endmodule

// File: rtl/msic_xor_bank.sv
module msic_xor_bank #(
  parameter int L  = 8,
  parameter int M  = 4,
  parameter int SW = 8,
  parameter int CW = $clog2(L + 1)
) (
  input  logic [SW-1:0] seed_i,
  input  logic [L-1:0]  ring_i,
  input  logic [CW-1:0] pos_i,
  input  logic          shift_on_i,
  output logic [L-1:0]  vec_o,
  output logic [M-1:0]  scan_o
);
  logic [L-1:0] pos_hit;
  logic         ring_bit;

  genvar j;
  generate
    for (j = 0; j < L; j++) begin : g_par
      assign vec_o[j]   = seed_i[j % SW] ^ ring_i[j];
      assign pos_hit[j] = (pos_i == CW'(j));
    end
  endgenerate

  assign ring_bit = |(pos_hit & ring_i);

  genvar i;
  generate
    for (i = 0; i < M; i++) begin : g_chain
      assign scan_o[i] = shift_on_i & (seed_i[i] ^ ring_bit);
    end
  endgenerate

endmodule

// File: rtl/msic_tpg.sv
module msic_tpg
  import msic_pkg::*;
#(
  parameter int          L          = 8,
  parameter int          M          = 4,
  parameter int          SW         = 8,
  parameter int unsigned SEED_RESET = 32'h5A
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init_i,
  input  logic         mode_i,
  input  logic         en_i,
  input  logic         out_ready_i,
  output logic         out_valid_o,
  output logic [L-1:0] vec_o,
  output logic [M-1:0] scan_in_o,
  output logic         scan_en_o,
  output logic         done_o
);
  localparam int CW = $clog2(L + 1);

  generate
    if (SW < M) begin : g_bad_seed_width
      $error("seed register narrower than chain count");
    end
    if (L < 2) begin : g_bad_len
      $error("chain length must be at least 2");
    end
  endgenerate

  tpg_mode_e     mode;
  logic          xfer;
  logic          ring_adv;
  logic          ring_wrap;
  logic [L-1:0]  ring;
  logic [SW-1:0] seed;
  logic [CW-1:0] pos;
  logic          shift_slot;
  logic          cap_slot;
  logic          seed_step;
  logic          scan_active;
  logic          done_q;

  assign mode        = tpg_mode_e'(mode_i);
  assign out_valid_o = en_i;
  assign xfer        = en_i && out_ready_i;
  assign ring_adv    = xfer && !init_i &&
                       ((mode == MODE_PER_CLOCK) || cap_slot);
  assign seed_step   = init_i || ring_wrap;
  assign scan_active = (mode == MODE_PER_SCAN) && shift_slot;

  msic_johnson #(.L(L)) u_ring (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (init_i),
    .adv_i   (ring_adv),
    .state_o (ring),
    .wrap_o  (ring_wrap)
  );

  msic_lfsr #(.SW(SW), .SEED_RESET(SEED_RESET)) u_seed (
    .clk    (clk),
    .rst    (rst),
    .step_i (seed_step),
    .seed_o (seed)
  );

  msic_scan_seq #(.L(L), .CW(CW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (init_i),
    .run_i     (mode == MODE_PER_SCAN),
    .step_i    (xfer),
    .pos_o     (pos),
    .shift_o   (shift_slot),
    .capture_o (cap_slot)
  );

  msic_xor_bank #(.L(L), .M(M), .SW(SW), .CW(CW)) u_xor (
    .seed_i     (seed),
    .ring_i     (ring),
    .pos_i      (pos),
    .shift_on_i (scan_active),
    .vec_o      (vec_o),
    .scan_o     (scan_in_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
    end else begin
      done_q <= ring_wrap;
    end
  end

  assign scan_en_o = scan_active;
  assign done_o    = done_q;

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_init_no_done_R9: assert property (@(posedge clk) disable iff (rst)
    init_i |=> !done_o);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i && !init_i) |=>
      ($stable(vec_o) && !done_o && (!$stable(mode_i) || $stable(scan_in_o))));

  assert_clock_mode_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 1'b0) |-> (!scan_en_o && scan_in_o == '0));

  assert_sic_step_R4: assert property (@(posedge clk) disable iff (rst)
    (ring_adv && !ring_wrap) |=> ($countones(vec_o ^ $past(vec_o)) == 1));

endmodule

// File: tb/test_msic_tpg.sv
module test_msic_tpg;
  localparam int  L      = 8;
  localparam int  M      = 4;
  localparam int  SW     = 8;
  localparam time CLK_PERIOD = 10;
  localparam logic [7:0] RESET_SEED = 8'h5A;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         init_i = 1'b0, mode_i = 1'b0, en_i = 1'b0, out_ready_i = 1'b0;
  logic         out_valid_o, scan_en_o, done_o;
  logic [L-1:0] vec_o;
  logic [M-1:0] scan_in_o;

  msic_tpg #(.L(L), .M(M), .SW(SW), .SEED_RESET(32'h5A)) i_msic_tpg (
    .clk(clk), .rst(rst), .init_i(init_i), .mode_i(mode_i), .en_i(en_i),
    .out_ready_i(out_ready_i), .out_valid_o(out_valid_o), .vec_o(vec_o),
    .scan_in_o(scan_in_o), .scan_en_o(scan_en_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_fail = 0, cycles = 0;

  // Reference model state
  int         m_p = 0, m_cnt = 0;
  logic [7:0] m_seed = RESET_SEED;
  logic       m_done = 1'b0;

  function automatic logic [7:0] lfsr_next(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic ring_bit(input int p, input int k);
    return (k < p) && (p <= k + L);
  endfunction

  function automatic logic [L-1:0] ring_pat(input int p);
    logic [L-1:0] r;
    for (int k = 0; k < L; k++) r[k] = ring_bit(p, k);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_p = 0; m_cnt = 0; m_seed = RESET_SEED; m_done = 1'b0;
    end else begin
      logic adv;
      adv = 1'b0;
      m_done = 1'b0;
      if (init_i) begin
        m_p = 0; m_cnt = 0; m_seed = lfsr_next(m_seed);
      end else begin
        if (!mode_i) m_cnt = 0;
        if (en_i && out_ready_i) begin
          if (!mode_i) adv = 1'b1;
          else if (m_cnt == L) begin m_cnt = 0; adv = 1'b1; end
          else m_cnt++;
        end
        if (adv) begin
          m_p++;
          if (m_p == 2*L) begin m_p = 0; m_seed = lfsr_next(m_seed); m_done = 1'b1; end
        end
      end
    end
  end

  // Per-cycle comparison plus SIC / no-repeat tracking
  logic [7:0]   last_seed = 8'h00;
  int           last_p = -1;
  logic [L-1:0] last_vec;
  logic [L-1:0] seen[$];

  always @(negedge clk) begin
    if (!rst) begin
      logic [L-1:0] ev;
      logic [M-1:0] es;
      logic         esen;
      for (int j = 0; j < L; j++) ev[j] = m_seed[j % SW] ^ ring_bit(m_p, j);
      esen = mode_i && (m_cnt < L);
      for (int i = 0; i < M; i++) es[i] = esen & (m_seed[i] ^ ring_bit(m_p, m_cnt));
      chk("R2 vec", 32'(vec_o), 32'(ev));
      chk("R3 ring", 32'(vec_o ^ m_seed), 32'(ring_pat(m_p)));
      chk("R7 scan_in", 32'(scan_in_o), 32'(es));
      chk("R7 scan_en", 32'(scan_en_o), 32'(esen));
      chk("R8 valid", 32'(out_valid_o), 32'(en_i));
      chk("R6 done", 32'(done_o), 32'(m_done));
      chk("R5 seed nonzero", 32'(m_seed != 0), 32'd1);
      if (m_seed != last_seed) begin
        seen.delete();
        seen.push_back(vec_o);
      end else if (m_p != last_p) begin
        int rep;
        rep = 0;
        foreach (seen[q]) if (seen[q] == vec_o) rep = 1;
        chk("R4 hamming", 32'($countones(vec_o ^ last_vec)), 32'd1);
        chk("R4 no repeat", 32'(rep), 32'd0);
        seen.push_back(vec_o);
      end
      last_seed = m_seed; last_p = m_p; last_vec = vec_o;
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin : stim
    logic [7:0] s_before;
    tick(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset vec", 32'(vec_o), 32'(RESET_SEED));
    chk("R1 reset done", 32'(done_o), 32'd0);
    chk("R1 reset scan_en", 32'(scan_en_o), 32'd0);
    tick(1);
    // R2/R3/R4/R6: free-running test-per-clock, two full periods
    en_i = 1'b1; out_ready_i = 1'b1;
    tick(40);
    // R8: stalls, including one on a pending wrap
    while (m_p != 2*L - 1) tick(1);
    out_ready_i = 1'b0;
    s_before = m_seed;
    tick(3);
    @(negedge clk);
    chk("R8 stall seed", 32'(vec_o ^ ring_pat(2*L-1)), 32'(s_before));
    chk("R8 stall done", 32'(done_o), 32'd0);
    tick(1);
    out_ready_i = 1'b1;
    tick(1);
    for (int c = 0; c < 30; c++) begin
      out_ready_i = (c % 3) != 1;
      tick(1);
    end
    out_ready_i = 1'b1;
    // R9: init coinciding with a wrap
    while (m_p != 2*L - 1) tick(1);
    s_before = m_seed;
    init_i = 1'b1;
    tick(1);
    init_i = 1'b0;
    @(negedge clk);
    chk("R9 single seed step", 32'(vec_o), 32'(lfsr_next(s_before)));
    chk("R9 no done", 32'(done_o), 32'd0);
    tick(5);
    // R7: test-per-scan, started with init
    mode_i = 1'b1; init_i = 1'b1;
    tick(1);
    init_i = 1'b0;
    tick(2 * 2 * L * (L + 1) + 5);
    for (int c = 0; c < 60; c++) begin
      out_ready_i = (c % 4) != 0;
      en_i = (c % 7) != 3;
      tick(1);
    end
    en_i = 1'b1; out_ready_i = 1'b1;
    // back to test-per-clock mid-load
    tick(4);
    mode_i = 1'b0;
    tick(20);
    en_i = 1'b0;
    tick(5);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule